// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the 8-bit arithmetic and logic stage of an accumulator-oriented processor. Each cycle it takes the accumulator value, a second operand and a 5-bit operation code. It combines them with the carry and auxiliary-carry bits held in its own flag register. It then presents the new accumulator value and a write strobe for the accumulator, and loads the updated status into the flag register on the clock edge.

The flag register holds five bits: sign, zero, auxiliary carry (the carry or borrow across the low nibble), even parity and carry. It is read out as one packed status byte. The block covers binary add and subtract with and without the stored carry, compare, the three bitwise operations, complement, four rotates, increment, decrement, carry set and carry toggle, and decimal adjust after a BCD addition. The surrounding pipeline owns operand fetch, decoding and the register file. It commits the returned value when the strobe is high.

Top module: `acc_alu`

## Requirements
- R1: While reset is active, and after it is released, the packed status byte reads 0x02 (all five flags clear).
- R2: The packed status byte places sign at bit 7, zero at bit 6, auxiliary carry at bit 4, parity at bit 2 and carry at bit 0. Bit 1 is always 1 and bits 5 and 3 are always 0.
- R3: ADD (op 0) returns acc+opnd. ADC (op 1) returns acc+opnd+CY. Carry takes the carry out of bit 7, and auxiliary carry takes the carry out of bit 3.
- R4: SUB (op 2) returns acc-opnd. SBB (op 3) returns acc-opnd-CY. Carry is set on a borrow out of bit 7, and auxiliary carry is set on a borrow out of the low nibble.
- R5: CMP (op 4) sets all five flags exactly as SUB would and never raises the accumulator write strobe.
- R6: For every operation that updates them (ops 0-7, 12, 13, 17), zero is set when the 8-bit result is 0, sign equals result bit 7, and parity is 1 when the result holds an even number of ones.
- R7: AND (op 5), XOR (op 6) and OR (op 7) clear both carry and auxiliary carry.
- R8: Rotates change only the carry flag. Rotate-left (op 8) and rotate-right (op 9) copy the bit that leaves into both the carry and the vacated end. Rotate-left-via-carry (op 10) and rotate-right-via-carry (op 11) put the old carry into the vacated end and the bit that leaves into carry.
- R9: Increment (op 12) and decrement (op 13) update zero, sign, parity and auxiliary carry, and keep carry unchanged.
- R10: Complement (op 14) inverts all accumulator bits and keeps every flag. Set-carry (op 15) forces carry to 1, and toggle-carry (op 16) inverts it. Neither of these two writes the accumulator.
- R11: Decimal adjust (op 17) first adds 0x06 if the low nibble exceeds 9 or auxiliary carry is set. It then adds 0x60 if the resulting high nibble exceeds 9, the first step carried out of bit 7, or carry is set. Carry is set whenever the 0x60 step applies, and auxiliary carry takes the carry out of the low nibble in the first step.
- R12: When the write enable is low, the flag register keeps its value and the accumulator write strobe stays low.
- R13: Op codes 18 to 31 change no flag, keep the strobe low and return the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Commit strobe for flags and accumulator |
| op | input | 5 | Operation code |
| acc_i | input | 8 | Current accumulator value |
| opnd_i | input | 8 | Second operand |
| res_o | output | 8 | New accumulator value (the difference for compare) |
| acc_wr_o | output | 1 | Accumulator write strobe |
| flags_o | output | 8 | Packed status byte from the flag register |

## Verification
The checker watches the fixed bits of the status byte on every cycle. It also checks that the flag register holds when the enable is low and that compare never writes. After every committed result-producing operation, it checks that the stored zero and parity bits agree with the previous result. It also checks that logic operations leave carry clear and that increment and decrement keep carry. The arithmetic values themselves can only be shown by the bench's scenarios: nibble carries and borrows, the four rotate paths, the two decimal-adjust corrections, and chained add-then-adjust sequences.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DW  = 8;
    localparam int NIB = DW / 2;
    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBB = 5'd3,
        OP_CMP = 5'd4,
        OP_AND = 5'd5,
        OP_XOR = 5'd6,
        OP_OR  = 5'd7,
        OP_RLC = 5'd8,
        OP_RRC = 5'd9,
        OP_RAL = 5'd10,
        OP_RAR = 5'd11,
        OP_INC = 5'd12,
        OP_DEC = 5'd13,
        OP_CMA = 5'd14,
        OP_STC = 5'd15,
        OP_CMC = 5'd16,
        OP_DAA = 5'd17
    } alu_op_e;

    typedef struct packed {
        logic s;
        logic z;
        logic ac;
        logic p;
        logic cy;
    } alu_flags_t;

    // Status byte layout: s z 0 ac 0 p 1 cy
    function automatic logic [7:0] pack_flags(alu_flags_t f);
        return {f.s, f.z, 1'b0, f.ac, 1'b0, f.p, 1'b1, f.cy};
    endfunction

    // Refresh the three result-derived flags
    function automatic alu_flags_t set_zsp(alu_flags_t f, logic [DW-1:0] v);
        alu_flags_t r;
        r   = f;
        r.z = (v == '0);
        r.s = v[DW-1];
        r.p = ~^v;
        return r;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         hc
);
    localparam int H = W / 2;

    logic [W-1:0] b_eff;
    logic         c0;
    logic [W:0]   full;
    logic [H:0]   low;

    // Subtraction as a + ~b + ~borrow; carry-outs invert to borrows
    always_comb begin
        b_eff = sub ? ~b : b;
        c0    = sub ? ~cin : cin;
        full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c0};
        low   = {1'b0, a[H-1:0]} + {1'b0, b_eff[H-1:0]} + {{H{1'b0}}, c0};
        sum   = full[W-1:0];
        cout  = sub ? ~full[W] : full[W];
        hc    = sub ? ~low[H]  : low[H];
    end
endmodule

// File: rtl/alu_logic_rot.sv
module alu_logic_rot
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [OPW-1:0] op,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           cy_in,
    output logic [W-1:0]   res,
    output logic           cy_out
);
    always_comb begin
        res    = a;
        cy_out = cy_in;
        case (op)
            OP_AND: res = a & b;
            OP_XOR: res = a ^ b;
            OP_OR:  res = a | b;
            OP_CMA: res = ~a;
            OP_RLC: begin
                res    = {a[W-2:0], a[W-1]};
                cy_out = a[W-1];
            end
            OP_RRC: begin
                res    = {a[0], a[W-1:1]};
                cy_out = a[0];
            end
            OP_RAL: begin
                res    = {a[W-2:0], cy_in};
                cy_out = a[W-1];
            end
            OP_RAR: begin
                res    = {cy_in, a[W-1:1]};
                cy_out = a[0];
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/alu_decadj.sv
module alu_decadj #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         ac_in,
    input  logic         cy_in,
    output logic [W-1:0] res,
    output logic         ac_out,
    output logic         cy_out
);
    localparam int H = W / 2;
    localparam logic [H-1:0] NINE = H'(9);
    localparam logic [H-1:0] SIX  = H'(6);

    logic         lo_fix;
    logic         hi_fix;
    logic [H:0]   lo_sum;
    logic [W:0]   stage1;

    always_comb begin
        lo_fix = ac_in || (a[H-1:0] > NINE);
        lo_sum = {1'b0, a[H-1:0]} + {1'b0, (lo_fix ? SIX : {H{1'b0}})};
        stage1 = {1'b0, a} + {{(W-H+1){1'b0}}, (lo_fix ? SIX : {H{1'b0}})};
        hi_fix = cy_in || stage1[W] || (stage1[W-1:H] > NINE);
        res    = stage1[W-1:0] + (hi_fix ? {SIX, {H{1'b0}}} : {W{1'b0}});
        ac_out = lo_sum[H];
        cy_out = hi_fix;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [OPW-1:0] op,
    input  logic [DW-1:0]  acc_i,
    input  logic [DW-1:0]  opnd_i,
    output logic [DW-1:0]  res_o,
    output logic           acc_wr_o,
    output logic [7:0]     flags_o
);
    typedef struct packed {
        logic [DW-1:0] res;
        logic          wr;
        alu_flags_t    flg;
    } alu_next_t;

    alu_flags_t flags_q, flags_d;
    alu_next_t  nx;

    // Shared adder operand selection
    logic [DW-1:0] add_b, add_sum;
    logic          add_sub, add_cin, add_cout, add_hc;

    always_comb begin
        add_b   = opnd_i;
        add_sub = 1'b0;
        add_cin = 1'b0;
        case (op)
            OP_ADC: add_cin = flags_q.cy;
            OP_SUB, OP_CMP: add_sub = 1'b1;
            OP_SBB: begin
                add_sub = 1'b1;
                add_cin = flags_q.cy;
            end
            OP_INC: add_b = DW'(1);
            OP_DEC: begin
                add_b   = DW'(1);
                add_sub = 1'b1;
            end
            default: ;
        endcase
    end

    alu_addsub #(.W(DW)) u_addsub (
        .a    (acc_i),
        .b    (add_b),
        .sub  (add_sub),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout),
        .hc   (add_hc)
    );

    logic [DW-1:0] lr_res;
    logic          lr_cy;

    alu_logic_rot #(.W(DW)) u_logic_rot (
        .op     (op),
        .a      (acc_i),
        .b      (opnd_i),
        .cy_in  (flags_q.cy),
        .res    (lr_res),
        .cy_out (lr_cy)
    );

    logic [DW-1:0] da_res;
    logic          da_ac, da_cy;

    alu_decadj #(.W(DW)) u_decadj (
        .a      (acc_i),
        .ac_in  (flags_q.ac),
        .cy_in  (flags_q.cy),
        .res    (da_res),
        .ac_out (da_ac),
        .cy_out (da_cy)
    );

    // Next-value computation
    always_comb begin
        nx.res = acc_i;
        nx.wr  = 1'b0;
        nx.flg = flags_q;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
                nx.res    = add_sum;
                nx.wr     = (op != OP_CMP);
                nx.flg    = set_zsp(flags_q, add_sum);
                nx.flg.cy = add_cout;
                nx.flg.ac = add_hc;
            end
            OP_AND, OP_XOR, OP_OR: begin
                nx.res    = lr_res;
                nx.wr     = 1'b1;
                nx.flg    = set_zsp(flags_q, lr_res);
                nx.flg.cy = 1'b0;
                nx.flg.ac = 1'b0;
            end
            OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                nx.res    = lr_res;
                nx.wr     = 1'b1;
                nx.flg.cy = lr_cy;
            end
            OP_CMA: begin
                nx.res = lr_res;
                nx.wr  = 1'b1;
            end
            OP_INC, OP_DEC: begin
                nx.res    = add_sum;
                nx.wr     = 1'b1;
                nx.flg    = set_zsp(flags_q, add_sum);
                nx.flg.ac = add_hc;
            end
            OP_STC: nx.flg.cy = 1'b1;
            OP_CMC: nx.flg.cy = ~flags_q.cy;
            OP_DAA: begin
                nx.res    = da_res;
                nx.wr     = 1'b1;
                nx.flg    = set_zsp(flags_q, da_res);
                nx.flg.cy = da_cy;
                nx.flg.ac = da_ac;
            end
            default: ;
        endcase
        flags_d = wr_en ? nx.flg : flags_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign res_o    = nx.res;
    assign acc_wr_o = nx.wr & wr_en;
    assign flags_o  = pack_flags(flags_q);

endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [4:0] op,
    input logic [7:0] res_o,
    input logic       acc_wr_o,
    input logic [7:0] flags_o
);
    logic past_ok;
    logic zsp_op;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assign zsp_op = (op <= 5'd7) || (op == 5'd12) || (op == 5'd13) || (op == 5'd17);

    // R2: fixed bits of the status byte
    a_r2_fixed_bits: assert property (@(posedge clk) disable iff (!rst_n)
        flags_o[1] && !flags_o[3] && !flags_o[5]);

    // R12: disabled cycle keeps the flag register
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !wr_en) |=> $stable(flags_o));

    // R5: compare never writes the accumulator
    a_r5_cmp_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 5'd4) |-> !acc_wr_o);

    // R6: stored zero matches previous committed result
    a_r6_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && wr_en && zsp_op) |=> (flags_o[6] == ($past(res_o) == 8'h00)));

    // R6: stored parity matches previous committed result
    a_r6_parity: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && wr_en && zsp_op) |=> (flags_o[2] == ~^$past(res_o)));

    // R7: logic ops leave carry clear
    a_r7_logic_cy: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && wr_en && (op >= 5'd5) && (op <= 5'd7)) |=> !flags_o[0]);

    // R9: increment/decrement keep carry
    a_r9_keep_cy: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && wr_en && ((op == 5'd12) || (op == 5'd13))) |=> $stable(flags_o[0]));

endmodule

bind acc_alu acc_alu_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .op       (op),
    .res_o    (res_o),
    .acc_wr_o (acc_wr_o),
    .flags_o  (flags_o)
);

// File: tb/acc_alu_tb.sv
module acc_alu_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] op = 5'd0;
    logic [7:0] acc_i = 8'h00;
    logic [7:0] opnd_i = 8'h00;
    logic [7:0] res_o;
    logic       acc_wr_o;
    logic [7:0] flags_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    acc_alu u_dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .op       (op),
        .acc_i    (acc_i),
        .opnd_i   (opnd_i),
        .res_o    (res_o),
        .acc_wr_o (acc_wr_o),
        .flags_o  (flags_o)
    );

    typedef struct packed {
        logic [4:0] op;
        logic [7:0] a;
        logic [7:0] b;
        logic       cy;    // carry established before the vector
        logic [7:0] res;
        logic       wr;
        logic [7:0] flg;
    } vec_t;

    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{5'd0,  8'h3A, 8'h47, 1'b0, 8'h81, 1'b1, 8'h96}, // R3 ADD nibble carry
        '{5'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 1'b1, 8'h57}, // R3 R6 ADD wrap
        '{5'd1,  8'h10, 8'h20, 1'b1, 8'h31, 1'b1, 8'h02}, // R3 ADC with carry
        '{5'd2,  8'h05, 8'h07, 1'b0, 8'hFE, 1'b1, 8'h93}, // R4 SUB borrow
        '{5'd3,  8'h50, 8'h20, 1'b1, 8'h2F, 1'b1, 8'h12}, // R4 SBB nibble borrow
        '{5'd4,  8'h42, 8'h42, 1'b1, 8'h00, 1'b0, 8'h46}, // R5 CMP equal
        '{5'd5,  8'hF8, 8'h0F, 1'b1, 8'h08, 1'b1, 8'h02}, // R7 AND clears carry
        '{5'd6,  8'hAA, 8'hAA, 1'b1, 8'h00, 1'b1, 8'h46}, // R7 XOR
        '{5'd7,  8'h80, 8'h01, 1'b0, 8'h81, 1'b1, 8'h86}, // R6 OR sign/parity
        '{5'd8,  8'h81, 8'h00, 1'b0, 8'h03, 1'b1, 8'h47}, // R8 rotate left
        '{5'd9,  8'h02, 8'h00, 1'b1, 8'h01, 1'b1, 8'h46}, // R8 rotate right
        '{5'd10, 8'h81, 8'h00, 1'b0, 8'h02, 1'b1, 8'h47}, // R8 left via carry
        '{5'd11, 8'h01, 8'h00, 1'b1, 8'h80, 1'b1, 8'h47}, // R8 right via carry
        '{5'd12, 8'hFF, 8'h00, 1'b1, 8'h00, 1'b1, 8'h57}, // R9 INC keeps carry
        '{5'd13, 8'h00, 8'h00, 1'b0, 8'hFF, 1'b1, 8'h96}, // R9 DEC borrow
        '{5'd14, 8'h5A, 8'h00, 1'b1, 8'hA5, 1'b1, 8'h47}, // R10 complement
        '{5'd16, 8'h33, 8'h00, 1'b1, 8'h33, 1'b0, 8'h46}, // R10 toggle carry
        '{5'd15, 8'h33, 8'h00, 1'b0, 8'h33, 1'b0, 8'h47}, // R10 set carry
        '{5'd31, 8'h6C, 8'h11, 1'b1, 8'h6C, 1'b0, 8'h47}, // R13 unused code
        '{5'd17, 8'h9B, 8'h00, 1'b0, 8'h01, 1'b1, 8'h13}, // R11 both corrections
        '{5'd17, 8'h15, 8'h00, 1'b1, 8'h75, 1'b1, 8'h03}  // R11 carry forces high
    };

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(logic [4:0] o, logic [7:0] a, logic [7:0] b, logic we);
        @(negedge clk);
        op = o; acc_i = a; opnd_i = b; wr_en = we;
    endtask

    // Establish flags 0x46 (carry 0) or 0x47 (carry 1)
    task automatic prep(logic cy);
        apply(5'd5, 8'h00, 8'h00, 1'b1);
        if (cy) apply(5'd15, 8'h00, 8'h00, 1'b1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 check("R1 reset value", flags_o, 8'h02);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1 check("R1 after release", flags_o, 8'h02);

        for (int i = 0; i < NV; i++) begin
            prep(VECS[i].cy);
            apply(VECS[i].op, VECS[i].a, VECS[i].b, 1'b1);
            #1;
            check($sformatf("vector %0d result", i), res_o, VECS[i].res);
            check($sformatf("vector %0d strobe", i), {7'd0, acc_wr_o}, {7'd0, VECS[i].wr});
            @(posedge clk);
            #1 check($sformatf("vector %0d flags", i), flags_o, VECS[i].flg);
        end

        // R12: disabled add keeps flags and strobe low
        prep(1'b0);
        apply(5'd0, 8'hFF, 8'h01, 1'b0);
        #1 check("R12 strobe low", {7'd0, acc_wr_o}, 8'h00);
        @(posedge clk);
        #1 check("R12 flags held", flags_o, 8'h46);

        // R11: BCD 38+45 then adjust gives 83
        prep(1'b0);
        apply(5'd0, 8'h38, 8'h45, 1'b1);
        #1 check("R3 BCD add raw", res_o, 8'h7D);
        apply(5'd17, 8'h7D, 8'h00, 1'b1);
        #1 check("R11 adjust result", res_o, 8'h83);
        @(posedge clk);
        #1 check("R11 adjust flags", flags_o, 8'h92);

        // R1: asynchronous reset mid-run
        prep(1'b1);
        @(negedge clk);
        wr_en = 1'b0;
        rst_n = 1'b0;
        #1 check("R1 async reset", flags_o, 8'h02);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule